// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory from three supply comparator flags. The flags are already digitized and synchronized to the clock. They report whether the supply is above 3.0 V (run level), above 2.8 V (protect level) and above 2.5 V (switch-back level). Before it acts on a flag, the block filters it so that a change counts only after the flag has held its new value for a programmable number of cycles.

From the filtered flags the block drives four outputs:
- a write-protect line to the memory;
- a bus-isolate line that makes the memory ignore its inputs and tristate its data outputs;
- a source select that picks between the main supply and the backup cell;
- a seal flag that reports whether the backup cell has been armed.

The thresholds are deliberately asymmetric. Protection follows the raw 2.8 V flag with no delay. The cell takes over when the run level is lost. Main supply comes back when the switch-back level returns. The cell is never switched in until the supply has been seen at run level once after a reset. From then on it stays armed through any number of supply cycles, and only the reset input disarms it. Write activity is neither counted nor limited.

Top module: `pfail_wp_sequencer`

## Requirements
- R1: While rstN is low, wrProtect=1, busIsolate=1, srcBackup=0 and cellEnabled=0, and all filtered flags read as low.
- R2: wrProtect is 1 in the same cycle in which the raw aboveProt input is 0. No filtering or clock edge sits in that path.
- R3: A change on any flag input takes effect at the DEB_CYCLES-th rising edge at which the input differs from its filtered value in consecutive cycles. A pulse of fewer cycles has no effect on any output.
- R4: wrProtect is 0 only while the filtered run flag, the filtered protect flag and the raw aboveProt input are all 1.
- R5: busIsolate equals wrProtect in every cycle.
- R6: cellEnabled becomes 1 one edge after the filtered run flag is first 1. It then stays 1 through any flag sequence until rstN is asserted.
- R7: When the filtered run flag falls while cellEnabled=1, srcBackup becomes 1 at the next edge, DEB_CYCLES+1 edges after the raw fall. It stays 1 while the supply falls further, including when the 2.5 V flag drops.
- R8: While cellEnabled=0, srcBackup is 0 whatever the flags do.
- R9: srcBackup returns to 0 at the edge after the filtered switch-back flag rises.
- R10: srcBackup is 0 whenever the filtered run flag is 1. This holds even if the switch-back flag never dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low factory/test reset; the only way to clear the seal |
| aboveRun | input | 1 | Supply above 3.0 V flag |
| aboveProt | input | 1 | Supply above 2.8 V flag |
| aboveSwitch | input | 1 | Supply above 2.5 V flag |
| wrProtect | output | 1 | Memory write protect, 1 = protected |
| busIsolate | output | 1 | 1 = memory inputs ignored and data outputs tristated |
| srcBackup | output | 1 | Power source select, 1 = backup cell, 0 = main supply |
| cellEnabled | output | 1 | Seal latch: 1 once the backup cell is armed |

## Verification
Directed supply walks separate the hysteresis paths:
- a full fall to below 2.5 V followed by a rise, which shows that the return to main supply tracks the 2.5 V flag rather than the 3.0 V flag;
- a shallow dip to 2.9 V and back, which shows the return happening on the run flag alone;
- flag pulses one cycle short of the filter length, which show that the filter rejects them;
- a protect drop checked before any clock edge, which shows the combinational protect path.

A bench model driven by a seeded random walk over supply bands with random hold times compares every output in every cycle. It reaches filter boundaries and band orders that the directed cases miss. A reset after the random walk confirms that only the reset input clears the seal.

// File: rtl/pfail_pkg.sv
package pfail_pkg;
  localparam int IDX_SW    = 0;
  localparam int IDX_PROT  = 1;
  localparam int IDX_RUN   = 2;
  localparam int NUM_FLAGS = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic sealSet;
    logic cellOn;
    logic cellOff;
  } pfStrobe_t;
endpackage

// File: rtl/pfail_debounce.sv
module pfail_debounce #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      state <= 1'b0;
    end else if (rawIn != state) begin
      if (cnt == LIM) begin
        state <= rawIn;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  assign filtOut = state;

  // R3
  deb_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != $past(state)) |-> ($past(cnt) == LIM && $past(rawIn) == state));
endmodule

// File: rtl/pfail_datapath.sv
module pfail_datapath
  import pfail_pkg::*;
#(
  parameter int DEB_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] rawFlags,
  input  pfStrobe_t            strobe,
  output logic [NUM_FLAGS-1:0] filtFlags,
  output logic                 sealed,
  output logic                 onCell
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
    pfail_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawFlags[g]),
      .filtOut(filtFlags[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sealed <= 1'b0;
      onCell <= 1'b0;
    end else begin
      if (strobe.sealSet) sealed <= 1'b1;
      if (strobe.cellOff)     onCell <= 1'b0;
      else if (strobe.cellOn) onCell <= 1'b1;
    end
  end

  // R6
  seal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sealed |=> sealed);

  // R8
  unsealed_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sealed |-> !onCell);
endmodule

// File: rtl/pfail_control.sv
module pfail_control
  import pfail_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] filtFlags,
  input  logic                 sealed,
  input  logic                 rawProt,
  output pfStrobe_t            strobe,
  output logic                 wrProtect,
  output logic                 busIsolate
);
  logic prevRun;
  logic prevSw;
  logic runNow;
  logic swNow;

  assign runNow = filtFlags[IDX_RUN];
  assign swNow  = filtFlags[IDX_SW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRun <= 1'b0;
      prevSw  <= 1'b0;
    end else begin
      prevRun <= runNow;
      prevSw  <= swNow;
    end
  end

  always_comb begin
    strobe.sealSet = runNow;
    strobe.cellOn  = sealed & prevRun & ~runNow;
    strobe.cellOff = runNow | (~prevSw & swNow);
  end

  // raw protect flag bypasses the filter so no late write can slip through
  assign wrProtect  = ~rawProt | ~filtFlags[IDX_PROT] | ~runNow;
  assign busIsolate = wrProtect;
endmodule

// File: rtl/pfail_wp_sequencer.sv
module pfail_wp_sequencer
  import pfail_pkg::*;
#(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic aboveRun,
  input  logic aboveProt,
  input  logic aboveSwitch,
  output logic wrProtect,
  output logic busIsolate,
  output logic srcBackup,
  output logic cellEnabled
);
  logic [NUM_FLAGS-1:0] rawFlags;
  logic [NUM_FLAGS-1:0] filtFlags;
  pfStrobe_t            strobe;
  logic                 sealed;
  logic                 onCell;

  always_comb begin
    rawFlags           = '0;
    rawFlags[IDX_SW]   = aboveSwitch;
    rawFlags[IDX_PROT] = aboveProt;
    rawFlags[IDX_RUN]  = aboveRun;
  end

  pfail_datapath #(.DEB_CYCLES(DEB_CYCLES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rawFlags (rawFlags),
    .strobe   (strobe),
    .filtFlags(filtFlags),
    .sealed   (sealed),
    .onCell   (onCell)
  );

  pfail_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .filtFlags (filtFlags),
    .sealed    (sealed),
    .rawProt   (aboveProt),
    .strobe    (strobe),
    .wrProtect (wrProtect),
    .busIsolate(busIsolate)
  );

  assign srcBackup   = onCell & ~filtFlags[IDX_RUN];
  assign cellEnabled = sealed;

  // R7
  cell_takeover_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(filtFlags[IDX_RUN]) && sealed) |=> srcBackup);

  // R9
  main_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(filtFlags[IDX_SW]) |=> !srcBackup);

  // R10
  run_on_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    filtFlags[IDX_RUN] |-> !srcBackup);
endmodule

// File: tb/sim_pfail_wp_sequencer.sv
module sim_pfail_wp_sequencer;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aboveRun = 1'b0, aboveProt = 1'b0, aboveSwitch = 1'b0;
  logic wrProtect, busIsolate, srcBackup, cellEnabled;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference model state
  logic [2:0] mFilt;
  int         mCnt [3];
  logic       mPrevRun, mPrevSw, mSeal, mCell;

  always #5 clk = ~clk;

  pfail_wp_sequencer #(.DEB_CYCLES(DEB)) u0 (
    .clk(clk), .rstN(rstN), .aboveRun(aboveRun), .aboveProt(aboveProt),
    .aboveSwitch(aboveSwitch), .wrProtect(wrProtect), .busIsolate(busIsolate),
    .srcBackup(srcBackup), .cellEnabled(cellEnabled)
  );

  task automatic modelReset();
    mFilt = '0; mPrevRun = 0; mPrevSw = 0; mSeal = 0; mCell = 0;
    for (int i = 0; i < 3; i++) mCnt[i] = 0;
  endtask

  function automatic logic [2:0] rawVec();
    return {aboveRun, aboveProt, aboveSwitch};
  endfunction

  task automatic modelStep(input logic [2:0] raw);
    logic on, off;
    on  = mSeal & mPrevRun & ~mFilt[2];
    off = mFilt[2] | (~mPrevSw & mFilt[0]);
    if (off) mCell = 0; else if (on) mCell = 1;
    if (mFilt[2]) mSeal = 1;
    mPrevRun = mFilt[2];
    mPrevSw  = mFilt[0];
    for (int i = 0; i < 3; i++) begin
      if (raw[i] != mFilt[i]) begin
        if (mCnt[i] == DEB - 1) begin mFilt[i] = raw[i]; mCnt[i] = 0; end
        else mCnt[i]++;
      end else mCnt[i] = 0;
    end
  endtask

  function automatic logic expWp();
    return ~aboveProt | ~mFilt[1] | ~mFilt[2];
  endfunction

  function automatic logic expSrc();
    return mCell & ~mFilt[2];
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpAll(input string tag);
    logic [3:0] act, exp;
    act = {wrProtect, busIsolate, srcBackup, cellEnabled};
    exp = {expWp(), expWp(), expSrc(), mSeal};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual wp/iso/src/seal=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setLevel(input int lv);
    aboveSwitch = (lv >= 1);
    aboveProt   = (lv >= 2);
    aboveRun    = (lv >= 3);
  endtask

  // hold a supply band for n cycles, comparing against the model every cycle
  task automatic applyLevel(input int lv, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      setLevel(lv);
      #1 cmpAll(tag);
      @(posedge clk);
      modelStep(rawVec());
    end
    #2;
  endtask

  initial begin
    int seed, lv, hold, r;
    seed = $urandom(32'h5EED);
    modelReset();
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 wrProtect", wrProtect, 1'b1);
    chk("R1 busIsolate", busIsolate, 1'b1);
    chk("R1 srcBackup", srcBackup, 1'b0);
    chk("R1 cellEnabled", cellEnabled, 1'b0);
    @(negedge clk) rstN = 1'b1;

    // R8 unsealed: wander below run level
    applyLevel(1, 6, "R8"); applyLevel(0, 6, "R8");
    applyLevel(2, 6, "R8"); applyLevel(1, 6, "R8");
    chk("R8 srcBackup", srcBackup, 1'b0);
    chk("R8 cellEnabled", cellEnabled, 1'b0);

    // R3 pulse one cycle short of the filter
    applyLevel(3, DEB - 1, "R3");
    applyLevel(2, 6, "R3");
    chk("R3 wrProtect", wrProtect, 1'b1);
    chk("R3 cellEnabled", cellEnabled, 1'b0);

    // R6 R4 first valid power-up
    applyLevel(3, 8, "R6");
    chk("R6 cellEnabled", cellEnabled, 1'b1);
    chk("R4 wrProtect", wrProtect, 1'b0);
    chk("R5 busIsolate", busIsolate, 1'b0);

    // R2 protect drop seen before any edge
    @(negedge clk);
    aboveProt = 1'b0;
    #1 chk("R2 wrProtect", wrProtect, 1'b1);
    chk("R5 busIsolate", busIsolate, 1'b1);
    aboveProt = 1'b1;
    @(posedge clk);
    modelStep(rawVec());
    #2;
    applyLevel(3, 4, "R2");
    chk("R3 wrProtect", wrProtect, 1'b0);

    // R7 fall into cell, then below 2.5 V
    applyLevel(2, DEB, "R7");
    chk("R7 srcBackup early", srcBackup, 1'b0);
    applyLevel(2, 1, "R7");
    chk("R7 srcBackup", srcBackup, 1'b1);
    applyLevel(1, 8, "R7");
    applyLevel(0, 8, "R7");
    chk("R7 srcBackup low", srcBackup, 1'b1);
    chk("R7 wrProtect", wrProtect, 1'b1);

    // R9 back to main at 2.5 V
    applyLevel(1, DEB, "R9");
    chk("R9 srcBackup pre", srcBackup, 1'b1);
    applyLevel(1, 1, "R9");
    chk("R9 srcBackup", srcBackup, 1'b0);
    chk("R9 wrProtect", wrProtect, 1'b1);

    // R10 shallow dip and recovery
    applyLevel(3, 8, "R10");
    applyLevel(2, 8, "R10");
    chk("R10 srcBackup dip", srcBackup, 1'b1);
    applyLevel(3, DEB, "R10");
    chk("R10 srcBackup", srcBackup, 1'b0);
    chk("R10 wrProtect", wrProtect, 1'b0);

    // random walk over supply bands
    lv = 3;
    for (int s = 0; s < 2500; s++) begin
      r = int'($urandom_range(0, 9));
      if (r < 4 && lv > 0) lv--;
      else if (r < 8 && lv < 3) lv++;
      else lv = int'($urandom_range(0, 3));
      hold = int'($urandom_range(1, 8));
      applyLevel(lv, hold, "R4 R5 R7 R9 R10 random");
    end
    chk("R6 seal kept", cellEnabled, 1'b1);

    // R6 only reset clears the seal
    @(negedge clk) rstN = 1'b0;
    modelReset();
    #1 chk("R6 seal cleared", cellEnabled, 1'b0);
    chk("R1 srcBackup", srcBackup, 1'b0);
    @(negedge clk) rstN = 1'b1;
    applyLevel(2, 8, "R8");
    chk("R8 srcBackup after reset", srcBackup, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule